// File: doc/BRIEF.md
# Key-Guarded System Control Register

This block is a single 32-bit control word on a simple synchronous register bus. It holds a small priority grouping selector and produces three one-clock request pulses for neighbouring reset and exception logic. To keep stray stores from changing it, every write must carry an unlock value in its upper half. A write without that value is dropped in full, and no field changes.

Reads are combinational. A read returns a fixed constant in the upper half, the stored grouping selector, and a constant data endianness flag. Every other bit reads as zero. Access needs the privilege flag. An access without it reads as zero and changes nothing, and no error is raised. The request bits are write-only. Writing a 1 to one of them, with a valid key, gives a single-cycle pulse on the matching output.

Top module: `sysctl_keyreg`

## Requirements
- R1: After reset, a privileged selected read returns 0xFA050000, and all three request outputs are low.
- R2: A privileged selected write whose bits 31:16 equal 0x05FA loads bits 10:8 into the grouping selector. The new value is visible on reads from the next clock edge.
- R3: A write whose bits 31:16 hold any value other than 0x05FA, including 0xFA05, leaves the grouping selector unchanged and raises no request output.
- R4: Bits 31:16 of every privileged selected read are 0xFA05, whatever value was written last.
- R5: Bit 15 (endianness, 0 = little-endian) and bits 14:11, 7:3 and 2:0 always read 0, even after a valid write that sets them.
- R6: A valid write with bit 0, 1 or 2 set drives vect_rst_o, vect_clr_o or sys_rst_req_o high for exactly the one cycle after the write edge. Each bit drives only its own output.
- R7: When priv_i is low, the read data is 0 and a write has no effect on the selector or the request outputs.
- R8: When sel_i is low, the read data is 0 and wr_en_i has no effect.
- R9: A valid write whose bits 2:0 are zero raises no request output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Address match for this register |
| wr_en_i | input | 1 | Write strobe, qualified by sel_i |
| priv_i | input | 1 | Access is privileged |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, zero unless selected and privileged |
| sys_rst_req_o | output | 1 | System reset request pulse (written bit 2) |
| vect_clr_o | output | 1 | Clear active vector state pulse (written bit 1) |
| vect_rst_o | output | 1 | Local vector reset pulse (written bit 0) |

## Verification
Read data has no register on its path. The bench therefore checks it in the same cycle the read inputs are applied, a short delay after it drives them on a falling edge. The grouping selector and the request pulses each pass through one register. Their effects are sampled at the falling edge after the write's rising edge. Each pulse is checked a second time one edge later, to confirm it has fallen back to zero after exactly one cycle.

// File: rtl/sysctl_keyreg_pkg.sv
package sysctl_keyreg_pkg;

   localparam int REQ_N = 3;

   typedef enum int {
      REQ_VECT_RST = 0,
      REQ_VECT_CLR = 1,
      REQ_SYS_RST  = 2
   } req_pos_e;

   typedef struct packed {
      logic sel;
      logic wr;
      logic priv;
   } bus_acc_t;

   function automatic logic acc_ok(input bus_acc_t a);
      return a.sel & a.priv;
   endfunction

endpackage

// File: rtl/sysctl_keyreg_gate.sv
module sysctl_keyreg_gate #(
   parameter int          KEY_W      = 16,
   parameter logic [15:0] UNLOCK_KEY = 16'h05FA
) (
   input  sysctl_keyreg_pkg::bus_acc_t acc_i,
   input  logic [KEY_W-1:0]            key_i,
   output logic                        rd_ok_o,
   output logic                        commit_o
);
   import sysctl_keyreg_pkg::*;

   logic key_match;

   always_comb begin
      key_match = (key_i == UNLOCK_KEY[KEY_W-1:0]);
      rd_ok_o   = acc_ok(acc_i);
      commit_o  = rd_ok_o & acc_i.wr & key_match;
   end

endmodule

// File: rtl/sysctl_keyreg_group.sv
module sysctl_keyreg_group #(
   parameter int GRP_W   = 3,
   parameter int GRP_RST = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [GRP_W-1:0] d_i,
   output logic [GRP_W-1:0] q_o
);
   localparam logic [GRP_W-1:0] RST_VAL = GRP_W'(GRP_RST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= RST_VAL;
      end else if (load_i) begin
         q_o <= d_i;
      end
   end

endmodule

// File: rtl/sysctl_keyreg_pulse.sv
module sysctl_keyreg_pulse #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fire_i,
   input  logic [N-1:0] bits_i,
   output logic [N-1:0] pulse_o
);
   for (genvar k = 0; k < N; k++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pulse_o[k] <= 1'b0;
         end else begin
            pulse_o[k] <= fire_i & bits_i[k];
         end
      end
   end

endmodule

// File: rtl/sysctl_keyreg_rmux.sv
module sysctl_keyreg_rmux #(
   parameter int          DATA_W       = 32,
   parameter int          KEY_W        = 16,
   parameter logic [15:0] READBACK_KEY = 16'hFA05,
   parameter int          GRP_W        = 3,
   parameter int          GRP_LSB      = 8,
   parameter int          ENDIAN_POS   = 15,
   parameter bit          BIG_ENDIAN   = 1'b0
) (
   input  logic              rd_ok_i,
   input  logic [GRP_W-1:0]  grp_i,
   output logic [DATA_W-1:0] rdata_o
);
   logic endian_bit;
   logic [DATA_W-1:0] word;

   if (BIG_ENDIAN) begin : g_big
      assign endian_bit = 1'b1;
   end else begin : g_little
      assign endian_bit = 1'b0;
   end

   always_comb begin
      word                         = '0;
      word[DATA_W-1 -: KEY_W]      = READBACK_KEY[KEY_W-1:0];
      word[GRP_LSB +: GRP_W]       = grp_i;
      word[ENDIAN_POS]             = endian_bit;
      rdata_o                      = rd_ok_i ? word : '0;
   end

endmodule

// File: rtl/sysctl_keyreg.sv
module sysctl_keyreg #(
   parameter int          DATA_W       = 32,
   parameter int          KEY_W        = 16,
   parameter logic [15:0] UNLOCK_KEY   = 16'h05FA,
   parameter logic [15:0] READBACK_KEY = 16'hFA05,
   parameter int          GRP_W        = 3,
   parameter int          GRP_LSB      = 8,
   parameter int          GRP_RST      = 0,
   parameter int          ENDIAN_POS   = 15,
   parameter bit          BIG_ENDIAN   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  logic              wr_en_i,
   input  logic              priv_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              sys_rst_req_o,
   output logic              vect_clr_o,
   output logic              vect_rst_o
);
   import sysctl_keyreg_pkg::*;

   localparam int KEY_LSB = DATA_W - KEY_W;
   localparam int GRP_MSB = GRP_LSB + GRP_W - 1;

   if (KEY_W > 16 || KEY_W < 1) begin : g_bad_key
      $error("KEY_W out of range");
   end
   if (GRP_MSB >= ENDIAN_POS || ENDIAN_POS >= KEY_LSB) begin : g_bad_layout
      $error("field layout overlaps");
   end
   if (GRP_LSB <= REQ_N) begin : g_bad_grp
      $error("group field overlaps request bits");
   end

   bus_acc_t         acc;
   logic             rd_ok;
   logic             commit;
   logic [GRP_W-1:0] grp_q;
   logic [REQ_N-1:0] req_q;
   logic             unused_wbits;

   assign acc = '{sel: sel_i, wr: wr_en_i, priv: priv_i};
   assign unused_wbits = ^{wdata_i[KEY_LSB-1:GRP_MSB+1], wdata_i[GRP_LSB-1:REQ_N]};

   sysctl_keyreg_gate #(
      .KEY_W      (KEY_W),
      .UNLOCK_KEY (UNLOCK_KEY)
   ) u_gate (
      .acc_i    (acc),
      .key_i    (wdata_i[DATA_W-1:KEY_LSB]),
      .rd_ok_o  (rd_ok),
      .commit_o (commit)
   );

   sysctl_keyreg_group #(
      .GRP_W   (GRP_W),
      .GRP_RST (GRP_RST)
   ) u_group (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (commit),
      .d_i    (wdata_i[GRP_MSB:GRP_LSB]),
      .q_o    (grp_q)
   );

   sysctl_keyreg_pulse #(
      .N (REQ_N)
   ) u_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire_i  (commit),
      .bits_i  (wdata_i[REQ_N-1:0]),
      .pulse_o (req_q)
   );

   sysctl_keyreg_rmux #(
      .DATA_W       (DATA_W),
      .KEY_W        (KEY_W),
      .READBACK_KEY (READBACK_KEY),
      .GRP_W        (GRP_W),
      .GRP_LSB      (GRP_LSB),
      .ENDIAN_POS   (ENDIAN_POS),
      .BIG_ENDIAN   (BIG_ENDIAN)
   ) u_rmux (
      .rd_ok_i (rd_ok),
      .grp_i   (grp_q),
      .rdata_o (rdata_o)
   );

   assign vect_rst_o    = req_q[REQ_VECT_RST];
   assign vect_clr_o    = req_q[REQ_VECT_CLR];
   assign sys_rst_req_o = req_q[REQ_SYS_RST];

endmodule

// File: rtl/sysctl_keyreg_chk.sv
module sysctl_keyreg_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        sel_i,
   input logic        wr_en_i,
   input logic        priv_i,
   input logic [31:0] wdata_i,
   input logic [31:0] rdata_o,
   input logic        sys_rst_req_o,
   input logic        vect_clr_o,
   input logic        vect_rst_o,
   input logic [2:0]  grp
);
   logic good_wr;
   logic [2:0] pulses;
   assign good_wr = sel_i && wr_en_i && priv_i && (wdata_i[31:16] == 16'h05FA);
   assign pulses  = {sys_rst_req_o, vect_clr_o, vect_rst_o};

   // R4
   a_r4_key_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && priv_i) |-> (rdata_o[31:16] == 16'hFA05));
   // R5
   a_r5_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata_o[15:11] == 5'd0) && (rdata_o[7:0] == 8'd0));
   // R7
   a_r7_unpriv_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !priv_i |-> (rdata_o == 32'd0));
   // R8
   a_r8_unsel_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_i |-> (rdata_o == 32'd0));
   // R3
   a_r3_no_pulse_unkeyed: assert property (@(posedge clk) disable iff (!rst_n)
      !good_wr |=> (pulses == 3'd0));
   a_r3_grp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !good_wr |=> $stable(grp));
   // R2
   a_r2_grp_load: assert property (@(posedge clk) disable iff (!rst_n)
      good_wr |=> (grp == $past(wdata_i[10:8])));
   // R6
   a_r6_pulse_match: assert property (@(posedge clk) disable iff (!rst_n)
      good_wr |=> (pulses == $past(wdata_i[2:0])));
   // R9
   a_r9_quiet_write: assert property (@(posedge clk) disable iff (!rst_n)
      (good_wr && wdata_i[2:0] == 3'd0) |=> (pulses == 3'd0));

endmodule

bind sysctl_keyreg sysctl_keyreg_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .sel_i         (sel_i),
   .wr_en_i       (wr_en_i),
   .priv_i        (priv_i),
   .wdata_i       (wdata_i),
   .rdata_o       (rdata_o),
   .sys_rst_req_o (sys_rst_req_o),
   .vect_clr_o    (vect_clr_o),
   .vect_rst_o    (vect_rst_o),
   .grp           (grp_q)
);

// File: tb/sim_sysctl_keyreg.sv
module sim_sysctl_keyreg;
   localparam time CLK_PERIOD = 10ns;
   localparam int  NVEC = 10;

   // {priv, sel, key[15:0], low[15:0], exp_grp[2:0], exp_pulses{sys,clr,vrst}}
   localparam logic [39:0] VEC [NVEC] = '{
      {1'b1, 1'b1, 16'h05FA, 16'h0500, 3'd5, 3'b000}, // R2 R9
      {1'b1, 1'b1, 16'h05FB, 16'h0307, 3'd5, 3'b000}, // R3
      {1'b1, 1'b1, 16'h05FA, 16'h0701, 3'd7, 3'b001}, // R6 vect reset
      {1'b1, 1'b1, 16'h05FA, 16'h0002, 3'd0, 3'b010}, // R6 clear active
      {1'b1, 1'b1, 16'h05FA, 16'h0204, 3'd2, 3'b100}, // R6 sys reset
      {1'b1, 1'b1, 16'hFA05, 16'h0607, 3'd2, 3'b000}, // R3 readback value as key
      {1'b0, 1'b1, 16'h05FA, 16'h0607, 3'd2, 3'b000}, // R7
      {1'b1, 1'b0, 16'h05FA, 16'h0407, 3'd2, 3'b000}, // R8
      {1'b1, 1'b1, 16'h05FA, 16'hFFFF, 3'd7, 3'b111}, // R5 R6
      {1'b1, 1'b1, 16'h05FA, 16'h0300, 3'd3, 3'b000}  // R2 R9
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_i = 1'b0;
   logic        wr_en_i = 1'b0;
   logic        priv_i = 1'b0;
   logic [31:0] wdata_i = '0;
   logic [31:0] rdata_o;
   logic        sys_rst_req_o, vect_clr_o, vect_rst_o;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sysctl_keyreg u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .sel_i         (sel_i),
      .wr_en_i       (wr_en_i),
      .priv_i        (priv_i),
      .wdata_i       (wdata_i),
      .rdata_o       (rdata_o),
      .sys_rst_req_o (sys_rst_req_o),
      .vect_clr_o    (vect_clr_o),
      .vect_rst_o    (vect_rst_o)
   );

   function automatic logic [31:0] exp_word(input logic [2:0] g);
      return {16'hFA05, 5'd0, g, 8'd0};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // read with inputs set at a falling edge; result is combinational
   task automatic do_read(input logic p, input logic s, output logic [31:0] d);
      sel_i = s; priv_i = p; wr_en_i = 1'b0; wdata_i = '0;
      #1;
      d = rdata_o;
   endtask

   // one write cycle: drive at negedge, return at next negedge
   task automatic do_write(input logic p, input logic s, input logic [31:0] w);
      sel_i = s; priv_i = p; wr_en_i = 1'b1; wdata_i = w;
      @(posedge clk);
      @(negedge clk);
      sel_i = 1'b0; priv_i = 1'b0; wr_en_i = 1'b0; wdata_i = '0;
   endtask

   function automatic logic [31:0] pulses();
      return {29'd0, sys_rst_req_o, vect_clr_o, vect_rst_o};
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      do_read(1'b1, 1'b1, rd);
      check("R1 reset word", rd, 32'hFA050000);
      check("R1 reset pulses", pulses(), 32'd0);

      // vector table
      for (int i = 0; i < NVEC; i++) begin
         logic [39:0] v;
         v = VEC[i];
         @(negedge clk);
         do_write(v[39], v[38], {v[37:22], v[21:6]});
         check($sformatf("R6 R9 vec%0d pulses", i), pulses(), {29'd0, v[2:0]});
         do_read(1'b1, 1'b1, rd);
         check($sformatf("R2 R3 R4 R5 vec%0d word", i), rd, exp_word(v[5:3]));
         @(posedge clk);
         #1;
         check($sformatf("R6 vec%0d pulse width", i), pulses(), 32'd0);
         sel_i = 1'b0; priv_i = 1'b0;
      end

      // R7 unprivileged read returns zero
      @(negedge clk);
      do_read(1'b0, 1'b1, rd);
      check("R7 unpriv read", rd, 32'd0);

      // R8 unselected read returns zero
      do_read(1'b1, 1'b0, rd);
      check("R8 unselected read", rd, 32'd0);

      // R7 unprivileged write with valid key raises no pulse
      @(negedge clk);
      do_write(1'b0, 1'b1, 32'h05FA_0507);
      check("R7 unpriv write pulses", pulses(), 32'd0);
      do_read(1'b1, 1'b1, rd);
      check("R7 unpriv write word", rd, exp_word(3'd3));

      // R5 bit 15 and reserved bits stay zero after valid write setting them
      @(negedge clk);
      do_write(1'b1, 1'b1, 32'h05FA_F8F8);
      do_read(1'b1, 1'b1, rd);
      check("R5 read-only bits", rd, exp_word(3'd0));

      // R1 reset mid-run restores reset word
      @(negedge clk);
      do_write(1'b1, 1'b1, 32'h05FA_0600);
      rst_n = 1'b0;
      #1;
      check("R1 async reset pulses", pulses(), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      do_read(1'b1, 1'b1, rd);
      check("R1 reset word again", rd, 32'hFA050000);

      sel_i = 1'b0; priv_i = 1'b0;
      @(negedge clk);
      finish_run();
   end

endmodule